// File: doc/BRIEF.md
# Input Change Interrupt Unit

This block watches two independent groups of four input pins and raises one interrupt request per group when an input moves away from a value software has chosen for it. Each group has three registers: an interrupt enable mask, a read-only view of the synchronized pin levels, and a comparison value. It also has a flag register. A bit whose comparison value is 1 wakes the processor when its pin falls low. A bit whose comparison value is 0 wakes it when its pin rises. Each bit can therefore pick its own edge polarity.

Software programs the comparison value to the level it considers idle and sets the enable bits it cares about. It then waits for the group's request line. The request line stays high until software writes 1 to bit 0 of the group's flag register. Rewriting the mask or the comparison value never produces an interrupt for a mismatch that was already present. Only a new movement of an input can do that.

Top module: `kin_change_irq`

## Requirements
- R1: There are two groups. Group 0 uses pins bits 3..0 and `irq_o[0]`. Group 1 uses pins bits 7..4 and `irq_o[1]`. An event in one group never affects the other group's flag.
- R2: After reset, every enable bit is 0, every comparison bit is 1 and both flags are 0.
- R3: Register map: group g sits at base address 4*g. Offset 0 is the enable mask (read/write). Offset 1 is the pin data (read-only: 1 for a high pin, 0 for a low pin). Offset 2 is the comparison value (read/write). Offset 3 holds the flag in bit 0, with bits 3..1 reading 0. Writes to offset 1 have no effect.
- R4: Each pin passes through two flip-flops. A pin change driven before a clock edge shows in the pin data register after the second edge.
- R5: A group's flag sets on the third clock edge after one of its inputs changes, provided that input's enable bit is 1 and its new level differs from its comparison bit.
- R6: An input whose enable bit is 0 never sets the flag.
- R7: The flag stays set until a write with bit 0 = 1 to the group's offset 3. A write with bit 0 = 0 leaves it set.
- R8: Writing the enable or comparison registers does not set the flag, even if an enabled bit then mismatches its comparison value.
- R9: An input change that brings the input to its comparison value does not set the flag.
- R10: If a set condition and a clearing write land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Asynchronous input pins, group g at bits 4g+3..4g |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr`, combinational |
| irq_o | output | 2 | Interrupt request per group (the flag) |

## Verification
The in-RTL assertions check on every cycle that:
- a set flag holds unless a clearing write arrives;
- a group with an all-zero mask cannot raise its flag;
- a clearing write with quiet inputs drops the flag;
- with unchanged synchronized inputs the flag cannot rise, whatever the register writes do.

Only the bench scenarios can show the rest:
- the exact three-edge latency;
- per-bit polarity chosen by the comparison value;
- independence between the two groups;
- the read-only pin register;
- set winning over a clear on the same edge.

// File: rtl/kin_change_irq.sv
module kin_change_irq #(
  parameter int GROUPS = 2,
  parameter int WIDTH  = 4,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int AW    = GW + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUPS*WIDTH-1:0] pins_i,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_wr,
  input  logic [WIDTH-1:0]        bus_wdata,
  output logic [WIDTH-1:0]        bus_rdata,
  output logic [GROUPS-1:0]       irq_o
);

  logic [WIDTH-1:0] en_q  [GROUPS];
  logic [WIDTH-1:0] cmp_q [GROUPS];
  logic [WIDTH-1:0] sync_q[GROUPS];
  logic [GROUPS-1:0] flag_q;

  for (genvar g = 0; g < GROUPS; g++) begin : grp
    logic [WIDTH-1:0] meta_q, prev_q;
    logic             hit, wsel, clr;

    wire [WIDTH-1:0] pins = pins_i[g*WIDTH +: WIDTH];
    assign wsel = bus_wr && (bus_addr[AW-1:2] == GW'(g));
    assign clr  = wsel && (bus_addr[1:0] == 2'd3) && bus_wdata[0];
    assign hit  = |(en_q[g] & (sync_q[g] ^ cmp_q[g]) & (sync_q[g] ^ prev_q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q    <= '1;
        sync_q[g] <= '1;
        prev_q    <= '1;
        en_q[g]   <= '0;
        cmp_q[g]  <= '1;
        flag_q[g] <= 1'b0;
      end else begin
        meta_q    <= pins;
        sync_q[g] <= meta_q;
        prev_q    <= sync_q[g];
        if (wsel && bus_addr[1:0] == 2'd0) en_q[g]  <= bus_wdata;
        if (wsel && bus_addr[1:0] == 2'd2) cmp_q[g] <= bus_wdata;
        flag_q[g] <= hit | (flag_q[g] & ~clr);
      end
    end

    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr) |=> flag_q[g]);
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[g] && en_q[g] == '0) |=> !flag_q[g]);
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && sync_q[g] == prev_q) |=> !flag_q[g]);
    a_r8_no_set_without_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[g] && sync_q[g] == prev_q) |=> !flag_q[g]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (bus_addr[AW-1:2] == GW'(g)) begin
        case (bus_addr[1:0])
          2'd0:    bus_rdata = en_q[g];
          2'd1:    bus_rdata = sync_q[g];
          2'd2:    bus_rdata = cmp_q[g];
          default: bus_rdata = {{(WIDTH-1){1'b0}}, flag_q[g]};
        endcase
      end
    end
  end

  assign irq_o = flag_q;

endmodule

// File: tb/tb_kin_change_irq.sv
module tb_kin_change_irq;
  logic       clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] pins_i = 8'hFF;
  logic [2:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0, bus_rdata;
  logic [1:0] irq_o;
  int nchk = 0, nfail = 0;

  kin_change_irq dut (.clk, .rst_n, .pins_i, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .irq_o);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  // {pins, we, addr, data, expected irq}
  localparam logic [17:0] VEC [16] = '{
    {8'hFF, 1'b1, 3'd0, 4'hF, 2'b00},  // R8 enable g0, no mismatch
    {8'hFE, 1'b0, 3'd0, 4'h0, 2'b01},  // R5 g0 bit0 falls
    {8'hFE, 1'b1, 3'd3, 4'h1, 2'b00},  // R7 clear
    {8'hFF, 1'b0, 3'd0, 4'h0, 2'b00},  // R9 return to compare value
    {8'hFF, 1'b1, 3'd2, 4'hE, 2'b00},  // R8 compare write creates mismatch
    {8'hFE, 1'b0, 3'd0, 4'h0, 2'b00},  // R9 fall to compare value 0
    {8'hFF, 1'b0, 3'd0, 4'h0, 2'b01},  // R5 rising edge polarity
    {8'hFF, 1'b1, 3'd3, 4'h0, 2'b01},  // R7 write 0 keeps flag
    {8'hFF, 1'b1, 3'd3, 4'h1, 2'b00},  // R7 clear
    {8'hEF, 1'b0, 3'd0, 4'h0, 2'b00},  // R6 g1 disabled
    {8'hEF, 1'b1, 3'd4, 4'h1, 2'b00},  // R8 enable with existing mismatch
    {8'hFF, 1'b0, 3'd0, 4'h0, 2'b00},  // R9 g1
    {8'hEF, 1'b0, 3'd0, 4'h0, 2'b10},  // R1 g1 only
    {8'h6F, 1'b0, 3'd0, 4'h0, 2'b10},  // R6 g1 bit3 masked
    {8'h6F, 1'b1, 3'd7, 4'h1, 2'b00},  // R7 clear g1
    {8'h6F, 1'b1, 3'd1, 4'h0, 2'b00}   // R3 pin register write ignored
  };

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d); check("R2 en0", 8'(d), 8'h0);
    rd(3'd2, d); check("R2 cmp0", 8'(d), 8'hF);
    rd(3'd6, d); check("R2 cmp1", 8'(d), 8'hF);
    rd(3'd3, d); check("R2 flag0", 8'(d), 8'h0);
    check("R2 irq", 8'(irq_o), 8'h0);

    for (int i = 0; i < 16; i++) begin
      pins_i = VEC[i][17:10];
      if (VEC[i][9]) wr(VEC[i][8:6], VEC[i][5:2]);
      else @(negedge clk);
      repeat (3) @(negedge clk);
      check($sformatf("vector %0d irq", i), 8'(irq_o), 8'(VEC[i][1:0]));
    end
    rd(3'd5, d); check("R3 pin1 read", 8'(d), 8'h6);
    rd(3'd1, d); check("R3 pin0 read-only", 8'(d), 8'hF);
    rd(3'd2, d); check("R3 cmp0 readback", 8'(d), 8'hE);
    rd(3'd7, d); check("R3 flag1 upper bits", 8'(d), 8'h0);

    // R4/R5 latency: g0 bit1 low, cmp bit1=1, enabled
    pins_i = 8'h6D;
    @(negedge clk);
    rd(3'd1, d); check("R4 one edge", 8'(d), 8'hF);
    @(negedge clk);
    rd(3'd1, d); check("R4 two edges", 8'(d), 8'hD);
    check("R5 not yet", 8'(irq_o), 8'h0);
    @(negedge clk);
    check("R5 third edge", 8'(irq_o), 8'h1);
    wr(3'd3, 4'h1);
    check("R7 cleared", 8'(irq_o), 8'h0);

    // R10 set and clear on same edge: bit2 low
    pins_i = 8'h69;
    repeat (2) @(negedge clk);
    wr(3'd3, 4'h1);
    check("R10 set wins", 8'(irq_o), 8'h1);
    wr(3'd3, 4'h1);
    check("R10 later clear", 8'(irq_o), 8'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule